// File: doc/BRIEF.md
# Single-Entry Pipeline FIFO

This block is a one-slot first-in first-out buffer for a pipeline stage. An upstream producer offers a word through an enqueue request, a downstream consumer takes the held word through a dequeue request, and the held word is always visible on a front-of-queue output while the slot is occupied. Requests are single-cycle pulses. They are collected during the cycle, and one update step turns them into the state change at the next rising clock edge.

When both requests arrive in the same cycle, the removal counts as happening first. An occupied slot can therefore take a new word in the same cycle that its current word leaves, so one stage sustains one transfer per clock. A newly written word never passes straight to the output in the cycle it is written. It appears only after the clock edge.

A request made while its ready output is low is dropped, and the error output is raised in that same cycle. The data width is a parameter with a default of 32 bits.

Top module: `fifo1_pipe`

## Requirements
- R1: Synchronous active-high reset empties the slot. In the first cycle after reset, deq_rdy and first_rdy are 0.
- R2: An accepted enqueue on an empty slot with no dequeue fills the slot. From the next cycle, first_rdy is 1 and first_data equals the enqueued word.
- R3: An accepted dequeue with no enqueue empties the slot. From the next cycle, first_rdy is 0.
- R4: enq_rdy is 1 exactly when the slot is empty or deq_req is 1 in that cycle. deq_rdy and first_rdy are both 1 exactly when the slot holds a word.
- R5: Enqueue and dequeue together on a full slot replace the held word. The slot stays full, and first_data shows the new word from the next cycle.
- R6: An enqueue on a full slot without a dequeue is ignored. The slot stays full, first_data is unchanged, and err is 1 in that cycle.
- R7: A dequeue on an empty slot is ignored and err is 1 in that cycle. A simultaneous enqueue still fills the slot, and without one the slot stays empty.
- R8: There is no bypass. In a cycle that writes a word, first_data still shows the word held at the start of that cycle.
- R9: err is 0 in any cycle in which every raised request has its ready output at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_req | input | 1 | Enqueue request pulse |
| enq_data | input | W | Word to enqueue |
| enq_rdy | output | 1 | An enqueue would be accepted this cycle |
| deq_req | input | 1 | Dequeue request pulse |
| deq_rdy | output | 1 | A dequeue would be accepted this cycle |
| first_rdy | output | 1 | first_data is valid |
| first_data | output | W | Word at the front of the queue |
| err | output | 1 | A request was raised while not ready |

## Verification
On every cycle, the assertions check the ready relations, the error flag, and the next state after each combination of requests: fill, drain, swap on a full slot, and ignored requests. The bench compares the design against a reference model. Its random stimulus reaches long back-to-back swap runs. It also checks values that no property follows: the exact words that come out, in order, across long sequences. It also checks that first_data holds the old word during a write cycle.

// File: rtl/fifo1_pkg.sv
package fifo1_pkg;

    typedef struct packed {
        logic enq;
        logic deq;
    } fifo1_pulse_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_FILL  = 2'd1,
        UPD_DRAIN = 2'd2,
        UPD_SWAP  = 2'd3
    } fifo1_upd_e;

    // removal is ordered before insertion, so a full slot may take a word
    function automatic logic enq_allowed(input logic held, input logic deq_pulse);
        return !held || deq_pulse;
    endfunction

    function automatic fifo1_upd_e pick_update(input fifo1_pulse_t p);
        fifo1_upd_e u;
        case ({p.enq, p.deq})
            2'b10:   u = UPD_FILL;
            2'b01:   u = UPD_DRAIN;
            2'b11:   u = UPD_SWAP;
            default: u = UPD_HOLD;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/fifo1_req.sv
module fifo1_req
    import fifo1_pkg::*;
(
    input  logic         held,
    input  logic         enq_req,
    input  logic         deq_req,
    output fifo1_pulse_t fire,
    output logic         enq_rdy,
    output logic         deq_rdy,
    output logic         err
);
    always_comb begin
        deq_rdy  = held;
        enq_rdy  = enq_allowed(held, deq_req);
        fire.deq = deq_req && held;
        fire.enq = enq_req && enq_rdy;
        err      = (enq_req && !enq_rdy) || (deq_req && !held);
    end
endmodule

// File: rtl/fifo1_commit.sv
module fifo1_commit
    import fifo1_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  fifo1_pulse_t fire,
    input  logic [W-1:0] wr_data,
    output logic         held,
    output logic [W-1:0] word
);
    fifo1_upd_e upd;

    always_comb upd = pick_update(fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            word <= '0;
        end else begin
            case (upd)
                UPD_FILL: begin
                    held <= 1'b1;
                    word <= wr_data;
                end
                UPD_DRAIN: held <= 1'b0;
                UPD_SWAP: begin
                    held <= 1'b1;
                    word <= wr_data;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fifo1_pipe.sv
module fifo1_pipe
    import fifo1_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enq_req,
    input  logic [W-1:0] enq_data,
    output logic         enq_rdy,
    input  logic         deq_req,
    output logic         deq_rdy,
    output logic         first_rdy,
    output logic [W-1:0] first_data,
    output logic         err
);
    fifo1_pulse_t fire;
    logic         held;
    logic [W-1:0] word;

    fifo1_req u_req (
        .held    (held),
        .enq_req (enq_req),
        .deq_req (deq_req),
        .fire    (fire),
        .enq_rdy (enq_rdy),
        .deq_rdy (deq_rdy),
        .err     (err)
    );

    fifo1_commit #(.W(W)) u_commit (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .wr_data (enq_data),
        .held    (held),
        .word    (word)
    );

    assign first_rdy  = held;
    assign first_data = word;
endmodule

// File: rtl/fifo1_pipe_chk.sv
module fifo1_pipe_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         enq_req,
    input logic [W-1:0] enq_data,
    input logic         enq_rdy,
    input logic         deq_req,
    input logic         deq_rdy,
    input logic         first_rdy,
    input logic [W-1:0] first_data,
    input logic         err
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!first_rdy && !deq_rdy));

    assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
        (!first_rdy && enq_req && !deq_req) |=> (first_rdy && first_data == $past(enq_data)));

    assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
        (first_rdy && deq_req && !enq_req) |=> !first_rdy);

    assert_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (enq_rdy == (!first_rdy || deq_req)) && (deq_rdy == first_rdy));

    assert_swap_R5: assert property (@(posedge clk) disable iff (rst)
        (first_rdy && enq_req && deq_req) |=> (first_rdy && first_data == $past(enq_data)));

    assert_full_enq_R6: assert property (@(posedge clk) disable iff (rst)
        (first_rdy && enq_req && !deq_req) |=> (first_rdy && $stable(first_data)));

    assert_full_enq_err_R6: assert property (@(posedge clk) disable iff (rst)
        (first_rdy && enq_req && !deq_req) |-> err);

    assert_empty_deq_R7: assert property (@(posedge clk) disable iff (rst)
        (!first_rdy && deq_req) |-> err);

    assert_empty_deq_state_R7: assert property (@(posedge clk) disable iff (rst)
        (!first_rdy && deq_req && !enq_req) |=> !first_rdy);

    assert_no_false_err_R9: assert property (@(posedge clk) disable iff (rst)
        ((!enq_req || enq_rdy) && (!deq_req || deq_rdy)) |-> !err);
endmodule

bind fifo1_pipe fifo1_pipe_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enq_req    (enq_req),
    .enq_data   (enq_data),
    .enq_rdy    (enq_rdy),
    .deq_req    (deq_req),
    .deq_rdy    (deq_rdy),
    .first_rdy  (first_rdy),
    .first_data (first_data),
    .err        (err)
);

// File: tb/tb_fifo1_pipe.sv
module tb_fifo1_pipe;
    localparam int W      = 32;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enq_req = 1'b0;
    logic [W-1:0] enq_data = '0;
    logic         deq_req = 1'b0;
    logic         enq_rdy, deq_rdy, first_rdy, err;
    logic [W-1:0] first_data;

    int  checks = 0;
    int  failures = 0;
    bit  m_held = 1'b0;
    logic [W-1:0] m_word = '0;

    always #(CLK_NS/2) clk = ~clk;

    fifo1_pipe #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .enq_req(enq_req), .enq_data(enq_data), .enq_rdy(enq_rdy),
        .deq_req(deq_req), .deq_rdy(deq_rdy),
        .first_rdy(first_rdy), .first_data(first_data), .err(err)
    );

    function automatic bit exp_enq_rdy(bit held, bit dq);
        return !held || dq;
    endfunction

    function automatic bit exp_err(bit held, bit eq, bit dq);
        return (eq && !exp_enq_rdy(held, dq)) || (dq && !held);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // state outputs, sampled at the falling edge
    task automatic check_state();
        check("R4 deq_rdy", W'(deq_rdy), W'(m_held));
        check("R1/R2/R3 first_rdy", W'(first_rdy), W'(m_held));
        if (m_held) check("R2/R5/R8 first_data", first_data, m_word);
    endtask

    // drive one cycle: check state, drive, check combinational outputs, update model
    task automatic cycle(bit eq, bit dq, logic [W-1:0] d);
        bit acc_e, acc_d;
        @(negedge clk);
        check_state();
        enq_req = eq; deq_req = dq; enq_data = d;
        #1;
        check("R4 enq_rdy", W'(enq_rdy), W'(exp_enq_rdy(m_held, dq)));
        check("R6/R7/R9 err", W'(err), W'(exp_err(m_held, eq, dq)));
        if (m_held) check("R8 first_data no bypass", first_data, m_word);
        acc_d = dq && m_held;
        acc_e = eq && exp_enq_rdy(m_held, dq);
        @(posedge clk);
        if (acc_d) m_held = 1'b0;
        if (acc_e) begin m_held = 1'b1; m_word = d; end
    endtask

    initial begin
        #(CLK_NS * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        @(negedge clk);
        check("R1 first_rdy after reset", W'(first_rdy), '0);
        check("R1 deq_rdy after reset", W'(deq_rdy), '0);
        // R7: dequeue on empty is ignored and flagged
        cycle(1'b0, 1'b1, 32'h0);
        // R7 with enqueue: still fills
        cycle(1'b1, 1'b1, 32'hA5A5_0001);
        // R3: drain
        cycle(1'b0, 1'b1, 32'h0);
        // R2: fill
        cycle(1'b1, 1'b0, 32'h1111_2222);
        // R6: enqueue on full ignored
        cycle(1'b1, 1'b0, 32'hDEAD_BEEF);
        // R5: swap runs
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 32'hC0DE_0000 + i);
        cycle(1'b0, 1'b1, 32'h0);
        cycle(1'b0, 1'b0, 32'h0);
        // random mix
        for (int i = 0; i < 2000; i++) begin
            cycle(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom);
        end
        @(negedge clk);
        check_state();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule